// File: doc/BRIEF.md
# Packed Lane Population Counter

This unit counts set bits in a 64-bit operand and returns the counts packed lane by lane. The caller picks a lane width of 2, 4, 8, 16, 32 or 64 bits. Each lane of the result then holds, as an unsigned integer occupying that whole lane, the number of ones in the matching lane of the operand.

Internally the counts are built by a reduction tree of masked shift-and-add steps. Each step merges neighbouring counts from the step beneath it. Every step of the tree is offered as a selectable result, so the caller can get more than the final scalar.

The operand is qualified by a valid strobe. The packed result is captured in a register, and a valid flag marks it one clock later. A typical use is a datapath that needs per-byte or per-halfword bit densities as well as whole-word weights, all from one shared unit.

Top module: `lane_popcount`

## Requirements
- R1: While reset is asserted (`rst_n` low), `out_valid` is 0 and `out_counts` is all zeros.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R3: With `size_sel` = 0, each 2-bit lane i of `out_counts` (bits 2i+1:2i) holds the number of ones in `in_word[2i+1:2i]`, a value from 0 to 2.
- R4: With `size_sel` = 1, each 4-bit lane holds the ones count of the matching 4 operand bits.
- R5: With `size_sel` = 2, each byte lane holds the ones count of the matching operand byte.
- R6: With `size_sel` = 3, each 16-bit lane holds the ones count of the matching operand halfword, and the bits above that count are zero.
- R7: With `size_sel` = 4, each 32-bit lane holds the ones count of the matching operand half, and the bits above that count are zero.
- R8: With `size_sel` = 5, `out_counts` holds the ones count of the whole operand, zero-extended to 64 bits.
- R9: `size_sel` values 6 and 7 give the same result as value 5.
- R10: When `in_valid` is low at a clock edge, `out_counts` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` and `size_sel` as valid this cycle |
| in_word | input | 64 | Operand whose ones are counted |
| size_sel | input | 3 | Lane width: 0=2, 1=4, 2=8, 3=16, 4=32, 5..7=64 bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_counts | output | 64 | Registered packed per-lane counts |

## Verification
The block has no parameters, so the bench builds it at its fixed 64-bit width. At that width every select code from 0 to 7 can be swept, including the two codes that alias the whole-word count. The bench applies each operand in a pattern table under all eight codes, then seeded random words, and compares every lane against a bit-by-bit count. The all-ones word drives each lane to its maximum, so any carry leaking across a lane boundary in the tree shows up. Single-bit words at lane edges expose errors in the masks and the shift distances.

// File: rtl/lane_popcount.sv
module lane_popcount (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_word,
  input  logic [2:0]  size_sel,
  output logic        out_valid,
  output logic [63:0] out_counts
);

  localparam logic [63:0] K_ODD   = 64'h5555_5555_5555_5555;
  localparam logic [63:0] K_PAIR  = 64'h3333_3333_3333_3333;
  localparam logic [63:0] K_NIB   = 64'h0F0F_0F0F_0F0F_0F0F;
  localparam logic [63:0] K_HALF  = 64'h001F_001F_001F_001F;
  localparam logic [63:0] K_WORD  = 64'h0000_003F_0000_003F;
  localparam logic [63:0] K_WHOLE = 64'h0000_0000_0000_007F;

  logic [63:0] c2, c4, c8, c16, c32, c64, pick;

  // each step merges neighbouring counts; above bytes, upper lane bits carry stale partial sums
  assign c2  = in_word - ((in_word >> 1) & K_ODD);
  assign c4  = (c2 & K_PAIR) + ((c2 >> 2) & K_PAIR);
  assign c8  = (c4 + (c4 >> 4)) & K_NIB;
  assign c16 = c8 + (c8 >> 8);
  assign c32 = c16 + (c16 >> 16);
  assign c64 = c32 + (c32 >> 32);

  always_comb begin
    case (size_sel)
      3'd0:    pick = c2;
      3'd1:    pick = c4;
      3'd2:    pick = c8;
      3'd3:    pick = c16 & K_HALF;
      3'd4:    pick = c32 & K_WORD;
      default: pick = c64 & K_WHOLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_counts <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_counts <= pick;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (!out_valid && out_counts == 64'd0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  p_lane_le2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 3'd0) |=> ((out_counts & (out_counts >> 1) & K_ODD) == 64'd0));

  p_whole_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel >= 3'd5) |=> (out_counts == 64'($countones($past(in_word)))));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_counts));

endmodule

// File: tb/sim_lane_popcount.sv
module sim_lane_popcount;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic [2:0]  size_sel = '0;
  logic        out_valid;
  logic [63:0] out_counts;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [63:0] VEC [10] = '{
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0001,
    64'h8000_0000_0000_0000,
    64'h0000_0001_8000_0000,
    64'h5555_5555_5555_5555,
    64'hAAAA_AAAA_AAAA_AAAA,
    64'h00FF_FF00_0F0F_F0F0,
    64'h0123_4567_89AB_CDEF,
    64'hFFFF_0000_0000_FFFF
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_popcount u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .size_sel(size_sel), .out_valid(out_valid), .out_counts(out_counts)
  );

  function automatic logic [63:0] ref_counts(input logic [63:0] w, input logic [2:0] s);
    int fw;
    logic [63:0] r;
    fw = (s >= 3'd5) ? 64 : (2 << s);
    r = '0;
    for (int l = 0; l < 64 / fw; l++) begin
      int cnt;
      cnt = 0;
      for (int b = 0; b < fw; b++) cnt += int'(w[l*fw + b]);
      r = r | (64'(cnt) << (l*fw));
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [2:0] s);
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] w, input logic [2:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    size_sel = s;
    @(negedge clk);
    check(64'(out_valid), 64'd1, "R2");
    check(out_counts, ref_counts(w, s), tag_for(s));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check(64'(out_valid), 64'd0, "R1");
    check(out_counts, 64'd0, "R1");
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++)
      for (int s = 0; s < 8; s++)
        apply(VEC[v], 3'(s));

    for (int i = 0; i < 300; i++) begin
      logic [63:0] rw;
      rw = {$urandom(), $urandom()};
      apply(rw, 3'(i % 8));
    end

    // R9: aliased codes against code 5 on one word
    apply(64'hDEAD_BEEF_0BAD_F00D, 3'd6);
    held = out_counts;
    apply(64'hDEAD_BEEF_0BAD_F00D, 3'd5);
    check(out_counts, held, "R9");

    // R10 and R2: idle cycles keep the result and drop valid
    apply(64'h0F0F_0000_FFFF_0001, 3'd2);
    held = out_counts;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 64'hFFFF_FFFF_FFFF_FFFF;
    size_sel = 3'd5;
    @(negedge clk);
    check(64'(out_valid), 64'd0, "R2");
    check(out_counts, held, "R10");
    @(negedge clk);
    check(out_counts, held, "R10");

    // R1: reset mid-run clears the output
    rst_n = 1'b0;
    #1;
    check(64'(out_valid), 64'd0, "R1");
    check(out_counts, 64'd0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    apply(64'h0000_0000_0000_0001, 3'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule